// File: doc/BRIEF.md
# Wait-State Stall Controller

This block sits next to a processor's execute stage and carries out a "pause until something needs attention" instruction. When an instruction of the wait class commits and its two-bit condition field is zero, a single wait flag is raised. While that flag is up, the block reports the pipeline as busy, and no further instruction is accepted for issue.

The flag drops as soon as any wake source is seen. The wake sources are a pending trace exception, an external interrupt request, a performance-monitor interrupt request, a negative decrementer, or an interrupt actually being taken. No interrupt-enable state takes part in this decision. If the condition field is non-zero, the instruction retires as a no-op. The block also merges the flag with the other units' busy lines, and it produces the issue-accept gate that the execute stage uses. Delivery of the interrupt itself is not part of this block.

Top module: `wait_stall_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the wait flag is 0, so busy_o is low when the three unit busy inputs are low.
- R2: A commit with commit_cls_i equal to CLS_WAIT (default 62) and commit_insn_i[22:21] equal to 2'b00 raises busy_o from the cycle after that commit edge, provided no wake source is present in that cycle.
- R3: A CLS_WAIT commit whose field commit_insn_i[22:21] is 01, 10 or 11 acts as a no-op and leaves busy_o low.
- R4: A commit of any class other than CLS_WAIT never raises the wait flag, whatever its bits 22:21 hold.
- R5: Each of trace_pend_i, ext_irq_i, pmu_irq_i, dec_i[63] and irq_taken_i, acting alone, clears the wait flag at the next clock edge. The block has no enable input, so no masking applies.
- R6: When a wake source and an arming commit occur in the same cycle, the flag ends up at 0.
- R7: busy_o is high whenever any of lsu_busy_i, exu_busy_i or fpu_busy_i is high, or the wait flag is set. It reacts in the same cycle.
- R8: issue_ok_o is high only when in_valid_i is high and busy_o, flush_i, redirect_i and irq_prog_i are all low.
- R9: A decrementer value with bit 63 clear never wakes the block, whatever its other bits hold.
- R10: Once set, the wait flag holds for as many cycles as no wake source appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| commit_i | input | 1 | An instruction's side effects commit this cycle |
| commit_cls_i | input | CLS_W | Operation class of the committing instruction |
| commit_insn_i | input | INSN_W | Instruction word of the committing instruction |
| trace_pend_i | input | 1 | Trace exception pending |
| ext_irq_i | input | 1 | External interrupt request |
| pmu_irq_i | input | 1 | Performance-monitor interrupt request |
| dec_i | input | DEC_W | Decrementer value; the top bit means negative |
| irq_taken_i | input | 1 | An interrupt is being taken |
| lsu_busy_i | input | 1 | Load/store unit busy |
| exu_busy_i | input | 1 | Execute stage busy |
| fpu_busy_i | input | 1 | Floating-point unit busy |
| in_valid_i | input | 1 | Incoming instruction valid |
| flush_i | input | 1 | Pipeline flush |
| redirect_i | input | 1 | Redirect in progress |
| irq_prog_i | input | 1 | Interrupt in progress |
| busy_o | output | 1 | Combined busy to the pipeline |
| issue_ok_o | output | 1 | Incoming instruction accepted this cycle |

## Verification
The flag is the only register in the block. An arming commit or a wake source therefore shows up on busy_o exactly one clock edge later. The bench drives each stimulus on a falling edge and checks busy_o on the next falling edge, which leaves one rising edge in between. The unit busy inputs and the issue gate are combinational, so the bench checks them a short delay after driving, with no clock edge in between. Holding behaviour is checked on several successive falling edges while no wake source is applied.

// File: rtl/wait_stall_ctrl.sv
module wait_stall_ctrl #(
  parameter int CLS_W    = 6,
  parameter int INSN_W   = 32,
  parameter int DEC_W    = 64,
  parameter int CLS_WAIT = 62,
  parameter int FLD_LO   = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [CLS_W-1:0]  commit_cls_i,
  input  logic [INSN_W-1:0] commit_insn_i,
  input  logic              trace_pend_i,
  input  logic              ext_irq_i,
  input  logic              pmu_irq_i,
  input  logic [DEC_W-1:0]  dec_i,
  input  logic              irq_taken_i,
  input  logic              lsu_busy_i,
  input  logic              exu_busy_i,
  input  logic              fpu_busy_i,
  input  logic              in_valid_i,
  input  logic              flush_i,
  input  logic              redirect_i,
  input  logic              irq_prog_i,
  output logic              busy_o,
  output logic              issue_ok_o
);
  localparam logic [CLS_W-1:0] WAIT_CODE = CLS_W'(CLS_WAIT);

  logic wait_q;
  logic [1:0] cond_fld;
  logic arm, wake;

  assign cond_fld = commit_insn_i[FLD_LO+1:FLD_LO];
  assign arm  = commit_i && (commit_cls_i == WAIT_CODE) && (cond_fld == 2'b00);
  assign wake = trace_pend_i | ext_irq_i | pmu_irq_i | dec_i[DEC_W-1] | irq_taken_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wait_q <= 1'b0;
    else if (wake) wait_q <= 1'b0;
    else if (arm)  wait_q <= 1'b1;
  end

  assign busy_o     = lsu_busy_i | exu_busy_i | fpu_busy_i | wait_q;
  assign issue_ok_o = in_valid_i & ~(busy_o | flush_i | redirect_i | irq_prog_i);
endmodule

// File: rtl/wait_stall_chk.sv
module wait_stall_chk #(
  parameter int CLS_W    = 6,
  parameter int INSN_W   = 32,
  parameter int DEC_W    = 64,
  parameter int CLS_WAIT = 62,
  parameter int FLD_LO   = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit_i,
  input logic [CLS_W-1:0]  commit_cls_i,
  input logic [INSN_W-1:0] commit_insn_i,
  input logic              trace_pend_i,
  input logic              ext_irq_i,
  input logic              pmu_irq_i,
  input logic [DEC_W-1:0]  dec_i,
  input logic              irq_taken_i,
  input logic              in_valid_i,
  input logic              flush_i,
  input logic              redirect_i,
  input logic              irq_prog_i,
  input logic              busy_o,
  input logic              issue_ok_o,
  input logic              wait_q
);
  logic c_wake, c_arm;
  assign c_wake = trace_pend_i || ext_irq_i || pmu_irq_i || dec_i[DEC_W-1] || irq_taken_i;
  assign c_arm  = commit_i && (commit_cls_i == CLS_W'(CLS_WAIT))
                  && (commit_insn_i[FLD_LO+1:FLD_LO] == 2'b00);

  AST_ARM_SETS:    assert property (@(posedge clk) disable iff (!rst_n) c_arm && !c_wake |=> wait_q); // R2
  AST_NO_ARM:      assert property (@(posedge clk) disable iff (!rst_n) !wait_q && !c_arm |=> !wait_q); // R3
  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) c_wake |=> !wait_q); // R5
  AST_HOLD:        assert property (@(posedge clk) disable iff (!rst_n) wait_q && !c_wake |=> wait_q); // R10
  AST_WAIT_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) wait_q |-> busy_o); // R7
  AST_ISSUE_GATE:  assert property (@(posedge clk) disable iff (!rst_n)
                     issue_ok_o |-> in_valid_i && !busy_o && !flush_i && !redirect_i && !irq_prog_i); // R8
endmodule

bind wait_stall_ctrl wait_stall_chk #(
  .CLS_W(CLS_W), .INSN_W(INSN_W), .DEC_W(DEC_W), .CLS_WAIT(CLS_WAIT), .FLD_LO(FLD_LO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .commit_i(commit_i), .commit_cls_i(commit_cls_i),
  .commit_insn_i(commit_insn_i), .trace_pend_i(trace_pend_i), .ext_irq_i(ext_irq_i),
  .pmu_irq_i(pmu_irq_i), .dec_i(dec_i), .irq_taken_i(irq_taken_i),
  .in_valid_i(in_valid_i), .flush_i(flush_i), .redirect_i(redirect_i),
  .irq_prog_i(irq_prog_i), .busy_o(busy_o), .issue_ok_o(issue_ok_o), .wait_q(wait_q)
);

// File: tb/tb_wait_stall_ctrl.sv
module tb_wait_stall_ctrl;
  localparam int CW = 6;
  localparam logic [5:0] WCLS = 6'd62;
  localparam logic [63:0] DEC_NEG = 64'h8000_0000_0000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic commit = 0, trace = 0, ext = 0, pmu = 0, taken = 0;
  logic lsu = 0, exu = 0, fpu = 0, valid = 0, flush = 0, redir = 0, iprog = 0;
  logic [CW-1:0] cls = '0;
  logic [31:0] insn = '0;
  logic [63:0] dec = '0;
  logic busy, issue_ok;
  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wait_stall_ctrl dut (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .commit_cls_i(cls), .commit_insn_i(insn),
    .trace_pend_i(trace), .ext_irq_i(ext), .pmu_irq_i(pmu), .dec_i(dec), .irq_taken_i(taken),
    .lsu_busy_i(lsu), .exu_busy_i(exu), .fpu_busy_i(fpu), .in_valid_i(valid),
    .flush_i(flush), .redirect_i(redir), .irq_prog_i(iprog), .busy_o(busy), .issue_ok_o(issue_ok)
  );

  // {class, field, wake mask {trace,ext,pmu,dec,taken}, expected busy next cycle}
  localparam logic [13:0] VEC [10] = '{
    {6'd62, 2'b00, 5'b00000, 1'b1},  // R2
    {6'd62, 2'b01, 5'b00000, 1'b0},  // R3
    {6'd62, 2'b10, 5'b00000, 1'b0},  // R3
    {6'd62, 2'b11, 5'b00000, 1'b0},  // R3
    {6'd1,  2'b00, 5'b00000, 1'b0},  // R4
    {6'd62, 2'b00, 5'b10000, 1'b0},  // R6
    {6'd62, 2'b00, 5'b01000, 1'b0},  // R6
    {6'd62, 2'b00, 5'b00100, 1'b0},  // R6
    {6'd62, 2'b00, 5'b00010, 1'b0},  // R6
    {6'd62, 2'b00, 5'b00001, 1'b0}   // R6
  };

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic idle();
    commit = 0; cls = '0; insn = '0; trace = 0; ext = 0; pmu = 0; dec = '0; taken = 0;
    lsu = 0; exu = 0; fpu = 0; valid = 0; flush = 0; redir = 0; iprog = 0;
  endtask

  task automatic set_wake(logic [4:0] m);
    trace = m[4]; ext = m[3]; pmu = m[2]; dec = m[1] ? DEC_NEG : '0; taken = m[0];
  endtask

  task automatic arm_wait();
    commit = 1; cls = WCLS; insn = 32'h7C00_003C & ~(32'h3 << 21);
    @(negedge clk);
    idle();
  endtask

  task automatic clear();
    taken = 1; @(negedge clk); idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    valid = 1;
    repeat (2) @(negedge clk);
    chk("R1 busy in reset", busy, 1'b0);
    chk("R1 issue in reset", issue_ok, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after reset", busy, 1'b0);
    idle();

    for (int i = 0; i < 10; i++) begin
      commit = 1; cls = VEC[i][13:8];
      insn = 32'h0000_0010 | (32'(VEC[i][7:6]) << 21) | 32'h0060_0000 & ~(32'h3 << 21);
      set_wake(VEC[i][5:1]);
      @(negedge clk);
      chk($sformatf("vec%0d R2/R3/R4/R6", i), busy, VEC[i][0]);
      idle();
      clear();
    end

    for (int s = 0; s < 5; s++) begin
      arm_wait();
      chk($sformatf("R2 armed before wake %0d", s), busy, 1'b1);
      valid = 1;
      #1 chk("R8 no issue while waiting", issue_ok, 1'b0);
      repeat (3) @(negedge clk);
      chk("R10 flag held", busy, 1'b1);
      set_wake(5'b10000 >> s);
      @(negedge clk);
      chk($sformatf("R5 wake source %0d clears", s), busy, 1'b0);
      idle();
    end

    arm_wait();
    dec = 64'h7FFF_FFFF_FFFF_FFFF;
    repeat (2) @(negedge clk);
    chk("R9 positive decrementer no wake", busy, 1'b1);
    idle();
    clear();
    chk("R5 cleared after dec test", busy, 1'b0);

    lsu = 1; #1 chk("R7 lsu busy", busy, 1'b1); lsu = 0;
    exu = 1; #1 chk("R7 exu busy", busy, 1'b1); exu = 0;
    fpu = 1; #1 chk("R7 fpu busy", busy, 1'b1); fpu = 0;
    #1 chk("R7 idle busy", busy, 1'b0);

    valid = 1;
    #1 chk("R8 issue accepted", issue_ok, 1'b1);
    flush = 1; #1 chk("R8 flush blocks", issue_ok, 1'b0); flush = 0;
    redir = 1; #1 chk("R8 redirect blocks", issue_ok, 1'b0); redir = 0;
    iprog = 1; #1 chk("R8 irq blocks", issue_ok, 1'b0); iprog = 0;
    exu = 1; #1 chk("R8 busy blocks", issue_ok, 1'b0); exu = 0;
    valid = 0; #1 chk("R8 invalid", issue_ok, 1'b0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule